// File: doc/BRIEF.md
# Discrete Sense Channel Array: Hysteresis and Self-Test Logic

This block holds the digital decision logic for a bank of discrete sense inputs. Each channel gets two synchronized comparator flags from analog circuitry outside the block. One flag means the pin voltage is above the upper threshold. The other means it is below the lower threshold. The channel turns these flags into a hysteretic logic level. The same latch serves both sensing modes. In ground/open mode the thresholds are about 10.5 V and 4.5 V. In supply/open mode they are about 12 V and 6 V. The analog side selects the thresholds, so this logic only sees the two flags.

Each channel also drives the controls for its pull-up switch and its pull-down switch. Its mode bit chooses which of the two closes. Both switches stay open until the part reports that it has been configured.

A global self-test enable replaces the comparator flags with values taken from each channel's mode bit. Software can then confirm that the whole digital path reproduces the pattern it wrote. An array wrapper instantiates one channel per input.

Top module: `disc_sense_array`

## Requirements
- R1: During reset and in the first cycle after it, every `sense_out` bit is 0 and every `pullup_en` and `pulldown_en` bit is 0. Reset is synchronous and active high.
- R2: While `cfg_done`=1 and `test_en`=0, a channel whose `above_hi`=1 and `below_lo`=0 shows `sense_out`=1 one clock later.
- R3: While `cfg_done`=1 and `test_en`=0, a channel whose `below_lo`=1 and `above_hi`=0 shows `sense_out`=0 one clock later.
- R4: While configured and not in test, a channel with both flags at 0 keeps its previous `sense_out`. This is the band between the thresholds.
- R5: While configured and not in test, a channel with both flags at 1 keeps its previous `sense_out`.
- R6: While `cfg_done`=0 and `test_en`=0, `sense_out` does not change, whatever the flags are.
- R7: While `cfg_done`=0, all switch controls are 0 (open) one clock later.
- R8: While `cfg_done`=1, a mode bit of 1 (ground/open) gives `pullup_en`=1 and `pulldown_en`=0 one clock later. A mode bit of 0 (supply/open) gives the reverse.
- R9: While `test_en`=1, each channel's `sense_out` equals its mode bit one clock later. This holds whatever the comparator flags and whatever `cfg_done` is.
- R10: The channels are independent. Each output bit depends only on the inputs of the same index.
- R11: `pullup_en` and `pulldown_en` are never both 1 on the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| above_hi | input | N_CH | Per channel: pin is above the upper threshold (synchronized) |
| below_lo | input | N_CH | Per channel: pin is below the lower threshold (synchronized) |
| mode | input | N_CH | Per channel: 1 = ground/open, 0 = supply/open |
| test_en | input | 1 | Global self-test enable |
| cfg_done | input | 1 | Configuration has been programmed |
| sense_out | output | N_CH | Registered hysteretic channel state |
| pullup_en | output | N_CH | Registered pull-up switch close control |
| pulldown_en | output | N_CH | Registered pull-down switch close control |

## Verification
The self-test override and a live comparator event can land in the same cycle. The bench raises `test_en` in the very cycle that the flags for a channel call for the opposite level. For example, `above_hi` is set while the mode bit is 0, and the output must follow the mode bit. It then drops `cfg_done` while test stays on. This confirms that the output still tracks the mode bit while the switches open. Every clock, a behavioural model built from the requirements is compared with all three output vectors. This covers directed phases and a long stretch of random flags, modes and control bits.

// File: rtl/disc_pkg.sv
package disc_pkg;

  // Comparator flag pair for one channel.
  typedef struct packed {
    logic hi;  // above the upper threshold
    logic lo;  // below the lower threshold
  } cmp_pair_t;

  typedef enum logic [1:0] {
    EVT_HOLD = 2'd0,
    EVT_SET  = 2'd1,
    EVT_CLR  = 2'd2,
    EVT_BOTH = 2'd3
  } hyst_evt_e;

  function automatic hyst_evt_e classify(input cmp_pair_t p);
    case ({p.hi, p.lo})
      2'b10:   return EVT_SET;
      2'b01:   return EVT_CLR;
      2'b11:   return EVT_BOTH;
      default: return EVT_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/disc_cmp_override.sv
module disc_cmp_override
  import disc_pkg::*;
(
  input  cmp_pair_t raw,
  input  logic      mode_bit,
  input  logic      test_en,
  output cmp_pair_t eff
);
  // In self-test the comparator inputs are both driven from the mode bit:
  // mode 1 reads as "above high", mode 0 as "below low".
  always_comb begin
    if (test_en) begin
      eff.hi = mode_bit;
      eff.lo = ~mode_bit;
    end else begin
      eff = raw;
    end
  end
endmodule

// File: rtl/disc_hyst_cell.sv
module disc_hyst_cell
  import disc_pkg::*;
#(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      upd_en,
  input  cmp_pair_t pair,
  output logic      state_q
);
  hyst_evt_e evt;

  always_comb evt = classify(pair);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RESET_VAL;
    end else if (upd_en) begin
      case (evt)
        EVT_SET: state_q <= 1'b1;
        EVT_CLR: state_q <= 1'b0;
        default: state_q <= state_q;  // in-band or conflicting flags
      endcase
    end
  end
endmodule

// File: rtl/disc_switch_ctl.sv
module disc_switch_ctl (
  input  logic clk,
  input  logic rst,
  input  logic cfg_done,
  input  logic mode_bit,
  output logic pu_q,
  output logic pd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pu_q <= 1'b0;
      pd_q <= 1'b0;
    end else begin
      pu_q <= cfg_done & mode_bit;
      pd_q <= cfg_done & ~mode_bit;
    end
  end
endmodule

// File: rtl/disc_sense_chan.sv
module disc_sense_chan
  import disc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic above_hi,
  input  logic below_lo,
  input  logic mode_bit,
  input  logic test_en,
  input  logic cfg_done,
  output logic state_q,
  output logic pu_q,
  output logic pd_q
);
  cmp_pair_t raw_pair;
  cmp_pair_t eff_pair;
  logic      upd_en;

  always_comb begin
    raw_pair.hi = above_hi;
    raw_pair.lo = below_lo;
    upd_en      = cfg_done | test_en;
  end

  disc_cmp_override u_ovr (
    .raw      (raw_pair),
    .mode_bit (mode_bit),
    .test_en  (test_en),
    .eff      (eff_pair)
  );

  disc_hyst_cell #(.RESET_VAL(1'b0)) u_hyst (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (upd_en),
    .pair    (eff_pair),
    .state_q (state_q)
  );

  disc_switch_ctl u_sw (
    .clk      (clk),
    .rst      (rst),
    .cfg_done (cfg_done),
    .mode_bit (mode_bit),
    .pu_q     (pu_q),
    .pd_q     (pd_q)
  );
endmodule

// File: rtl/disc_sense_array.sv
module disc_sense_array #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] above_hi,
  input  logic [N_CH-1:0] below_lo,
  input  logic [N_CH-1:0] mode,
  input  logic            test_en,
  input  logic            cfg_done,
  output logic [N_CH-1:0] sense_out,
  output logic [N_CH-1:0] pullup_en,
  output logic [N_CH-1:0] pulldown_en
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    disc_sense_chan u_ch (
      .clk      (clk),
      .rst      (rst),
      .above_hi (above_hi[g]),
      .below_lo (below_lo[g]),
      .mode_bit (mode[g]),
      .test_en  (test_en),
      .cfg_done (cfg_done),
      .state_q  (sense_out[g]),
      .pu_q     (pullup_en[g]),
      .pd_q     (pulldown_en[g])
    );
  end
endmodule

// File: rtl/disc_sense_chk.sv
module disc_sense_chk #(
  parameter int N_CH = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [N_CH-1:0] above_hi,
  input logic [N_CH-1:0] below_lo,
  input logic [N_CH-1:0] mode,
  input logic            test_en,
  input logic            cfg_done,
  input logic [N_CH-1:0] sense_out,
  input logic [N_CH-1:0] pullup_en,
  input logic [N_CH-1:0] pulldown_en
);
  // R1: reset clears every output
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sense_out == '0 && pullup_en == '0 && pulldown_en == '0));

  // R2: lone above-high flag sets the channel
  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_done && !test_en) |=>
      ((sense_out & $past(above_hi & ~below_lo)) == $past(above_hi & ~below_lo)));

  // R3: lone below-low flag clears the channel
  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_done && !test_en) |=>
      ((sense_out & $past(below_lo & ~above_hi)) == '0));

  // R4, R5: in-band or conflicting flags hold the state
  assert_hold_band_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_done && !test_en) |=>
      ((sense_out & $past(~(above_hi ^ below_lo))) ==
       ($past(sense_out) & $past(~(above_hi ^ below_lo)))));

  // R6: unconfigured outside test freezes the output
  assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_done && !test_en) |=> $stable(sense_out));

  // R7: switches open while unconfigured
  assert_open_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_done |=> (pullup_en == '0 && pulldown_en == '0));

  // R8: switch selection follows mode once configured
  assert_mode_sw_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> (pullup_en == $past(mode) && pulldown_en == ~$past(mode)));

  // R9: self-test output mirrors the mode bits
  assert_test_mirror_R9: assert property (@(posedge clk) disable iff (rst)
    test_en |=> (sense_out == $past(mode)));

  // R11: never both switches closed
  assert_sw_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    (pullup_en & pulldown_en) == '0);
endmodule

bind disc_sense_array disc_sense_chk #(.N_CH(N_CH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .above_hi    (above_hi),
  .below_lo    (below_lo),
  .mode        (mode),
  .test_en     (test_en),
  .cfg_done    (cfg_done),
  .sense_out   (sense_out),
  .pullup_en   (pullup_en),
  .pulldown_en (pulldown_en)
);

// File: tb/sim_disc_sense_array.sv
`timescale 1ns/1ps
module sim_disc_sense_array;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] above_hi = '0;
  logic [N-1:0] below_lo = '0;
  logic [N-1:0] mode = '0;
  logic         test_en = 1'b0;
  logic         cfg_done = 1'b0;
  logic [N-1:0] sense_out;
  logic [N-1:0] pullup_en;
  logic [N-1:0] pulldown_en;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // Behavioural reference state
  logic [N-1:0] ref_out = '0;
  logic [N-1:0] ref_pu = '0;
  logic [N-1:0] ref_pd = '0;

  always #5 clk = ~clk;

  disc_sense_array #(.N_CH(N)) u0 (
    .clk(clk), .rst(rst), .above_hi(above_hi), .below_lo(below_lo),
    .mode(mode), .test_en(test_en), .cfg_done(cfg_done),
    .sense_out(sense_out), .pullup_en(pullup_en), .pulldown_en(pulldown_en)
  );

  always @(posedge clk) begin
    if (rst) begin
      ref_out = '0; ref_pu = '0; ref_pd = '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit h, l;
        if (test_en) begin
          h = mode[i]; l = !mode[i];
        end else begin
          h = above_hi[i]; l = below_lo[i];
        end
        if (cfg_done || test_en) begin
          if (h && !l) ref_out[i] = 1'b1;
          else if (l && !h) ref_out[i] = 1'b0;
        end
        ref_pu[i] = cfg_done && mode[i];
        ref_pd[i] = cfg_done && !mode[i];
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Advance one clock, then compare outputs against the model away from the edge.
  task automatic tick();
    @(posedge clk);
    #1;
    check(cur_req, "sense_out", sense_out, ref_out);
    check(cur_req, "pullup_en", pullup_en, ref_pu);
    check(cur_req, "pulldown_en", pulldown_en, ref_pd);
    // R11 exclusivity at the ports
    check("R11", "both switches", pullup_en & pulldown_en, '0);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset
    cur_req = "R1";
    run(3);
    rst = 1'b0;
    above_hi = 8'hFF; mode = 8'hA5;
    // R6/R7: unconfigured, no test
    tick();
    check("R1", "sense_out after reset", sense_out, 8'h00);
    cur_req = "R6";
    run(3);
    check("R6", "frozen output", sense_out, 8'h00);
    check("R7", "pullups open", pullup_en, 8'h00);
    check("R7", "pulldowns open", pulldown_en, 8'h00);

    // R8: configure
    cur_req = "R8";
    above_hi = 8'h00; cfg_done = 1'b1;
    run(2);
    check("R8", "pullup from mode", pullup_en, 8'hA5);
    check("R8", "pulldown from mode", pulldown_en, 8'h5A);

    // R2: set
    cur_req = "R2";
    above_hi = 8'h3C;
    tick();
    check("R2", "set bits", sense_out, 8'h3C);

    // R4: in band hold
    cur_req = "R4";
    above_hi = 8'h00; below_lo = 8'h00;
    run(3);
    check("R4", "hold in band", sense_out, 8'h3C);

    // R3: clear
    cur_req = "R3";
    below_lo = 8'h0C;
    tick();
    check("R3", "clear bits", sense_out, 8'h30);

    // R5: conflicting flags hold
    cur_req = "R5";
    above_hi = 8'hFF; below_lo = 8'hFF;
    run(2);
    check("R5", "hold on conflict", sense_out, 8'h30);

    // R10: mixed per-channel pattern
    cur_req = "R10";
    above_hi = 8'h81; below_lo = 8'h42;
    tick();
    check("R10", "independent channels", sense_out, 8'hB1);

    // R9: test raised in the same cycle as opposing flags
    cur_req = "R9";
    mode = 8'h5A; above_hi = 8'hA5; below_lo = 8'h5A; test_en = 1'b1;
    tick();
    check("R9", "test mirrors mode", sense_out, 8'h5A);
    // drop configuration while test stays on
    cfg_done = 1'b0; mode = 8'h0F;
    tick();
    check("R9", "test without config", sense_out, 8'h0F);
    check("R7", "switches open in test unconfigured", pullup_en | pulldown_en, 8'h00);

    // R6: leave test while unconfigured: frozen
    cur_req = "R6";
    test_en = 1'b0; above_hi = 8'hF0; below_lo = 8'h0F;
    run(3);
    check("R6", "frozen after test", sense_out, 8'h0F);

    // Random stretch against the model
    cur_req = "R10";
    for (int k = 0; k < 400; k++) begin
      above_hi = N'($urandom);
      below_lo = N'($urandom);
      mode     = N'($urandom);
      test_en  = ($urandom % 5) == 0;
      cfg_done = ($urandom % 4) != 0;
      tick();
    end

    // R1: reset mid-run
    cur_req = "R1";
    rst = 1'b1;
    tick();
    check("R1", "reset mid-run out", sense_out, 8'h00);
    check("R1", "reset mid-run sw", pullup_en | pulldown_en, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule